// File: doc/BRIEF.md
# I2C Burst Data Buffer Bank

This block is the register bank that sits between a host register port and the serial byte engine of an I2C master. It keeps eight transmit data words, eight receive data words, the address byte for the target device and the number of data bytes in one burst. The host fills the transmit words, sets the address byte and the byte count, then starts the burst. The engine sends the address byte first. It then moves the data bytes one at a time through a request/accept handshake.

A single mode bit sets how many bytes each data word holds. In narrow mode each word carries one byte, so a burst moves at most 8 bytes. In wide mode each word carries four bytes, so a burst moves at most 32 bytes. The same bit also sets how many bits of the count field are used. Bytes are packed little-endian inside a word: the lowest byte lane comes first, and byte four moves on to the next word.

The bank sequences the bytes by index and reports when the last byte has been accepted. While a burst runs, the data and configuration registers are locked against writes.

Top module: `i2cb_bank`

## Requirements
- R1: After synchronous reset every register reads as zero, and `xfer_active`, `byte_req` and `xfer_done` are low.
- R2: Register map, with word address on `reg_addr`. Transmit words are at 0..7 and read back what was written. Receive words are at 8..15 and are read-only. The address byte is at 16, stored from bits [7:0]. The count is at 17. Control is at 18: bit 0 is enable, bit 1 is done (read-only), and bit 6 is wide mode.
- R3: Bits [3:0] of the count are used in narrow mode and bits [5:0] in wide mode. A masked value above the capacity (8 narrow, 32 wide) is clamped to the capacity. Address 17 reads back the effective count under the current mode.
- R4: Writing control with bit 0 set while idle starts a burst in the next cycle, with the byte index at zero. `slave_addr` presents the stored address byte, and `xfer_read` equals its bit 0.
- R5: In wide mode, data byte k on `tx_byte` comes from word k/4, bits [8*(k%4)+7 : 8*(k%4)].
- R6: In narrow mode, data byte k on `tx_byte` comes from bits [7:0] of word k.
- R7: In a read burst, each accepted `rx_byte` is stored at the same position as R5 or R6. In wide mode the other lanes of the word are kept. In narrow mode the upper 24 bits of the word become zero.
- R8: The byte index advances by one for each cycle in which both `byte_req` and `byte_ack` are high. `byte_req` drops once the index equals the count, and `xfer_done` and control bit 1 then read high.
- R9: With a count of zero, `xfer_done` is high in the first active cycle and `byte_req` never rises.
- R10: While a burst is active, writes to transmit words, the address byte, the count and the mode bit are ignored. A control write with bit 0 clear ends the burst.
- R11: `byte_ack` without `byte_req` changes neither the byte index nor the receive words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| slave_addr | output | 8 | Address byte for the engine to send first |
| xfer_active | output | 1 | Burst in progress |
| xfer_read | output | 1 | Burst direction, high for read |
| byte_req | output | 1 | A data byte is still due |
| tx_byte | output | 8 | Current transmit byte |
| byte_ack | input | 1 | Engine accepts the current byte |
| rx_byte | input | 8 | Received byte, taken on accept in read bursts |
| xfer_done | output | 1 | All counted bytes have been moved |

## Verification
The assertions assume that the host never writes control with bit 0 set during the cycle in which it also expects a byte to complete from an idle state. They also assume that the engine raises `byte_ack` freely, whether or not a byte is requested. The stimulus therefore stalls acknowledgements at random inside a burst and keeps acknowledging after `xfer_done`. During a burst it writes random data to the transmit words, the address byte and the count. It never writes to control in the middle of a burst, so each burst runs to its count before it is ended.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int LANES    = WORD_W / BYTE_W;
    localparam int CTL_EN   = 0;
    localparam int CTL_DONE = 1;
    localparam int CTL_WIDE = 6;

    typedef enum logic [2:0] {
        SEL_TX,
        SEL_RX,
        SEL_ADDR,
        SEL_CNT,
        SEL_CTL,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(int unsigned a, int unsigned n);
        if (a < n)             return SEL_TX;
        else if (a < 2 * n)    return SEL_RX;
        else if (a == 2 * n)   return SEL_ADDR;
        else if (a == 2*n + 1) return SEL_CNT;
        else if (a == 2*n + 2) return SEL_CTL;
        else                   return SEL_NONE;
    endfunction

    function automatic int unsigned word_of(int unsigned idx, logic wide);
        return wide ? idx / LANES : idx;
    endfunction

    function automatic int unsigned lane_of(int unsigned idx, logic wide);
        return wide ? idx % LANES : 0;
    endfunction

    function automatic int unsigned eff_count(int unsigned raw, logic wide,
                                              int unsigned n);
        int unsigned fw;
        int unsigned cap;
        int unsigned m;
        fw  = wide ? $clog2(n * LANES) + 1 : $clog2(n) + 1;
        cap = wide ? n * LANES : n;
        m   = raw & ((32'd1 << fw) - 1);
        return (m > cap) ? cap : m;
    endfunction

endpackage

// File: rtl/i2cb_seq.sv
module i2cb_seq #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          active,
    output logic [CW-1:0] idx,
    output logic          req,
    output logic          done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else begin
            if (stop) active <= 1'b0;
            if (step) idx <= idx + 1'b1;
        end
    end

    assign req  = active && (idx != limit);
    assign done = active && (idx == limit);
endmodule

// File: rtl/i2cb_txbank.sv
module i2cb_txbank import i2cb_pkg::*; #(
    parameter int NUM_REGS = 8,
    parameter int CW       = 6,
    parameter int RIW      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RIW-1:0]    wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [RIW-1:0]    rd_slot,
    output logic [WORD_W-1:0] rd_word,
    input  logic [CW-1:0]     idx,
    input  logic              wide,
    output logic [BYTE_W-1:0] cur_byte
);
    logic [WORD_W-1:0] regs [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_slot] <= wr_data;
        end
    end

    assign rd_word = regs[rd_slot];

    always_comb begin
        int unsigned w;
        int unsigned l;
        w = word_of(int'(idx), wide);
        l = lane_of(int'(idx), wide);
        cur_byte = '0;
        if (w < NUM_REGS) cur_byte = regs[w[RIW-1:0]][l*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/i2cb_rxbank.sv
module i2cb_rxbank import i2cb_pkg::*; #(
    parameter int NUM_REGS = 8,
    parameter int CW       = 6,
    parameter int RIW      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store,
    input  logic [CW-1:0]     idx,
    input  logic              wide,
    input  logic [BYTE_W-1:0] din,
    input  logic [RIW-1:0]    rd_slot,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] words [NUM_REGS];
    int unsigned       hit_w;
    int unsigned       hit_l;

    assign hit_w = word_of(int'(idx), wide);
    assign hit_l = lane_of(int'(idx), wide);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (store && hit_w == g) begin
                if (wide) word_q[hit_l*BYTE_W +: BYTE_W] <= din;
                else      word_q <= {{(WORD_W-BYTE_W){1'b0}}, din};
            end
        end
        assign words[g] = word_q;
    end

    assign rd_word = words[rd_slot];
endmodule

// File: rtl/i2cb_bank.sv
module i2cb_bank import i2cb_pkg::*; #(
    parameter  int NUM_REGS = 8,
    localparam int AW  = $clog2(2 * NUM_REGS + 3),
    localparam int CW  = $clog2(NUM_REGS * LANES) + 1,
    localparam int RIW = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] slave_addr,
    output logic              xfer_active,
    output logic              xfer_read,
    output logic              byte_req,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              byte_ack,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              xfer_done
);
    reg_sel_e          sel;
    logic [RIW-1:0]    slot;
    logic [BYTE_W-1:0] addr_q;
    logic [CW-1:0]     cnt_raw_q;
    logic [CW-1:0]     cnt_eff;
    logic              wide_q;
    logic [CW-1:0]     byte_idx;
    logic              cfg_we, start, stop, step;
    logic [WORD_W-1:0] tx_rd_word, rx_rd_word;

    assign sel    = decode_sel(int'(reg_addr), NUM_REGS);
    assign slot   = reg_addr[RIW-1:0];
    assign cfg_we = reg_we && !xfer_active;
    assign start  = reg_we && sel == SEL_CTL && reg_wdata[CTL_EN] && !xfer_active;
    assign stop   = reg_we && sel == SEL_CTL && !reg_wdata[CTL_EN];
    assign step   = byte_req && byte_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            cnt_raw_q <= '0;
            wide_q    <= 1'b0;
        end else if (cfg_we) begin
            case (sel)
                SEL_ADDR: addr_q    <= reg_wdata[BYTE_W-1:0];
                SEL_CNT:  cnt_raw_q <= reg_wdata[CW-1:0];
                SEL_CTL:  wide_q    <= reg_wdata[CTL_WIDE];
                default: ;
            endcase
        end
    end

    assign cnt_eff    = CW'(eff_count(int'(cnt_raw_q), wide_q, NUM_REGS));
    assign slave_addr = addr_q;
    assign xfer_read  = addr_q[0];

    i2cb_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .step(step),
        .limit(cnt_eff), .active(xfer_active), .idx(byte_idx),
        .req(byte_req), .done(xfer_done)
    );

    i2cb_txbank #(.NUM_REGS(NUM_REGS), .CW(CW), .RIW(RIW)) u_tx (
        .clk(clk), .rst(rst), .wr_en(cfg_we && sel == SEL_TX),
        .wr_slot(slot), .wr_data(reg_wdata), .rd_slot(slot),
        .rd_word(tx_rd_word), .idx(byte_idx), .wide(wide_q),
        .cur_byte(tx_byte)
    );

    i2cb_rxbank #(.NUM_REGS(NUM_REGS), .CW(CW), .RIW(RIW)) u_rx (
        .clk(clk), .rst(rst), .store(step && xfer_read), .idx(byte_idx),
        .wide(wide_q), .din(rx_byte), .rd_slot(slot), .rd_word(rx_rd_word)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_TX:   reg_rdata = tx_rd_word;
            SEL_RX:   reg_rdata = rx_rd_word;
            SEL_ADDR: reg_rdata[BYTE_W-1:0] = addr_q;
            SEL_CNT:  reg_rdata[CW-1:0] = cnt_eff;
            SEL_CTL: begin
                reg_rdata[CTL_EN]   = xfer_active;
                reg_rdata[CTL_DONE] = xfer_done;
                reg_rdata[CTL_WIDE] = wide_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2cb_bank_checker.sv
module i2cb_bank_checker #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          xfer_active,
    input logic          byte_req,
    input logic          byte_ack,
    input logic          xfer_done,
    input logic [7:0]    slave_addr,
    input logic [CW-1:0] byte_idx
);
    a_r8_idx_step: assert property (@(posedge clk) disable iff (rst)
        (byte_req && byte_ack) |=> (byte_idx == $past(byte_idx) + 1'b1));

    a_r8_done_no_req: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> !byte_req);

    a_r9_req_needs_active: assert property (@(posedge clk) disable iff (rst)
        byte_req |-> xfer_active);

    a_r10_addr_held: assert property (@(posedge clk) disable iff (rst)
        xfer_active |=> $stable(slave_addr));

    a_r11_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && !byte_req) |=> $stable(byte_idx));
endmodule

bind i2cb_bank i2cb_bank_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .xfer_active(xfer_active), .byte_req(byte_req),
    .byte_ack(byte_ack), .xfer_done(xfer_done), .slave_addr(slave_addr),
    .byte_idx(byte_idx)
);

// File: tb/i2cb_bank_bench.sv
module i2cb_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  slave_addr, tx_byte;
    logic [7:0]  rx_byte = '0;
    logic        xfer_active, xfer_read, byte_req, xfer_done;
    logic        byte_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_tx [8];
    logic [31:0] m_rx [8];
    logic [7:0]  m_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cb_bank u_i2cb_bank (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slave_addr(slave_addr),
        .xfer_active(xfer_active), .xfer_read(xfer_read), .byte_req(byte_req),
        .tx_byte(tx_byte), .byte_ack(byte_ack), .rx_byte(rx_byte),
        .xfer_done(xfer_done)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk_rd(string tag, int a, logic [31:0] exp);
        reg_addr = 5'(a);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    function automatic int eff(int raw, bit wide);
        int m;
        int cap;
        m   = raw & (wide ? 63 : 15);
        cap = wide ? 32 : 8;
        return (m > cap) ? cap : m;
    endfunction

    function automatic logic [7:0] exp_byte(int k, bit wide);
        return wide ? m_tx[k/4][8*(k%4) +: 8] : m_tx[k][7:0];
    endfunction

    task automatic run_xfer(bit rd, bit wide, int cnt);
        int ec;
        int k;
        ec = eff(cnt, wide);
        m_addr = {7'($urandom), rd};
        wr(16, {24'h0, m_addr});
        wr(18, 32'(wide) << 6);
        wr(17, 32'(cnt));
        wr(18, (32'(wide) << 6) | 32'h1);
        check("R4 active", {31'h0, xfer_active}, 32'h1);
        check("R4 slave_addr", {24'h0, slave_addr}, {24'h0, m_addr});
        check("R4 direction", {31'h0, xfer_read}, {31'h0, rd});
        if (ec == 0) check("R9 no request", {31'h0, byte_req}, 32'h0);
        k = 0;
        for (int it = 0; it < 400 && !xfer_done; it++) begin
            if (byte_req && !rd)
                check(wide ? "R5 wide tx byte" : "R6 narrow tx byte",
                      {24'h0, tx_byte}, {24'h0, exp_byte(k, wide)});
            byte_ack = byte_req && ($urandom % 3 != 0);
            rx_byte  = 8'($urandom);
            if (byte_ack) begin
                if (rd) begin
                    if (wide) m_rx[k/4][8*(k%4) +: 8] = rx_byte;
                    else      m_rx[k] = {24'h0, rx_byte};
                end
                k++;
            end
            if ($urandom % 4 == 0) begin
                reg_we    = 1'b1;
                reg_addr  = ($urandom % 2 == 0) ? 5'($urandom % 8) : 5'(16 + $urandom % 2);
                reg_wdata = $urandom;
            end
            @(negedge clk);
            byte_ack = 1'b0; reg_we = 1'b0;
        end
        check("R8 bytes moved", 32'(k), 32'(ec));
        check("R8 done", {31'h0, xfer_done}, 32'h1);
        check("R8 request low", {31'h0, byte_req}, 32'h0);
        chk_rd("R8 ctrl done bit", 18, (32'(wide) << 6) | 32'h3);
        // R11: acknowledgements with no request outstanding
        for (int i = 0; i < 3; i++) begin
            byte_ack = 1'b1; rx_byte = 8'($urandom);
            @(negedge clk);
        end
        byte_ack = 1'b0;
        check("R11 done held", {31'h0, xfer_done}, 32'h1);
        wr(18, 32'(wide) << 6);
        check("R10 stop", {31'h0, xfer_active}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            chk_rd("R10 tx locked", i, m_tx[i]);
            chk_rd("R7 rx word", 8 + i, m_rx[i]);
        end
        chk_rd("R10 addr locked", 16, {24'h0, m_addr});
        chk_rd("R10 count locked", 17, 32'(ec));
    endtask

    initial begin
        void'($urandom(32'h1C2B));
        for (int i = 0; i < 8; i++) begin m_tx[i] = '0; m_rx[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 active", {31'h0, xfer_active}, 32'h0);
        check("R1 req", {31'h0, byte_req}, 32'h0);
        check("R1 done", {31'h0, xfer_done}, 32'h0);
        for (int a = 0; a < 19; a++) chk_rd("R1 reg zero", a, 32'h0);

        for (int i = 0; i < 8; i++) begin
            m_tx[i] = $urandom;
            wr(i, m_tx[i]);
        end
        for (int i = 0; i < 8; i++) chk_rd("R2 tx readback", i, m_tx[i]);
        wr(8, 32'hFFFF_FFFF);
        chk_rd("R2 rx read-only", 8, 32'h0);
        wr(16, 32'h0000_01A5);
        chk_rd("R2 addr byte", 16, 32'hA5);
        wr(18, 32'h40);
        chk_rd("R2 wide bit", 18, 32'h40);

        wr(17, 40);
        chk_rd("R3 wide clamp", 17, 32);
        wr(17, 20);
        chk_rd("R3 wide value", 17, 20);
        wr(18, 32'h0);
        chk_rd("R3 narrow mask", 17, 4);
        wr(17, 12);
        chk_rd("R3 narrow clamp", 17, 8);
        wr(17, 63);
        chk_rd("R3 narrow mask clamp", 17, 8);
        wr(17, 5);
        chk_rd("R3 narrow value", 17, 5);

        run_xfer(0, 0, 8);
        run_xfer(0, 1, 32);
        run_xfer(1, 1, 7);
        run_xfer(1, 0, 3);
        run_xfer(0, 0, 0);
        run_xfer(1, 1, 0);
        run_xfer(0, 0, 12);
        run_xfer(1, 1, 32);
        for (int n = 0; n < 6; n++) begin
            for (int i = 0; i < 8; i++) begin
                m_tx[i] = $urandom;
                wr(i, m_tx[i]);
            end
            run_xfer(1'($urandom), 1'($urandom), int'($urandom % 64));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule